// File: doc/BRIEF.md
# Saturating Counting Semaphore Cell

This block is one storage cell of an inter-thread synchronisation unit. It holds a counting semaphore. A read through a semaphore view performs the take (P) operation, and a write through a semaphore view performs the give (V) operation. Each requester carries a small ID. A requester that tries a blocking take while the count is zero is told to stall, and its ID is recorded in a waiter bitmask. The next give releases every recorded waiter at once with a single wake pulse, and each released requester then retries.

Each access selects one of four views. The two semaphore views differ only in what happens on a take at zero: one blocks and the other polls. A raw view reads the count without side effects. A tag view returns a status word with empty and full flags and a software trap bit. Address decode to cell and view happens upstream. Each cycle carries at most one access, and the block answers reads combinationally in that cycle.

Top module: `sem_cell`

## Requirements
- R1: A read in view 2 (blocking) or view 3 (polling) returns the count as it stood before that read, zero-extended on `rdata_o`.
- R2: Such a read with a nonzero count lowers the count by exactly 1 at the clock edge.
- R3: A view 2 read at count 0 raises `block_o` in the same cycle and sets bit `req_id_i` of `waiters_o` after the edge. A view 3 read at count 0 returns 0, never raises `block_o`, and leaves the count at 0.
- R4: A write in view 2 or 3 raises the count by 1 when it is below 0xFFFF. At 0xFFFF the count stays unchanged.
- R5: A view 2 or 3 write while `waiters_o` is nonzero drives `wake_o` high for exactly the following cycle and clears `waiters_o` at the same edge.
- R6: A give ignores `wdata_i`. Views 2 and 3 behave identically on writes.
- R7: A view 0 write has no effect. A view 0 read returns the count and does not change it.
- R8: A view 1 read returns a word with bit 0 = (count == 0), bit 1 = (count == 0xFFFF), bit 16 = trap flag, and all other bits 0. A view 1 write loads the trap flag from `wdata_i[16]` and changes nothing else.
- R9: While `rst_ni` is low, the count, the trap flag, `waiters_o` and `wake_o` are all zero.
- R10: Views 4 to 7 read as 0, and writes to them have no effect.
- R11: When `rd_i` and `wr_i` are both high, only the read is performed.
- R12: With `rd_i` low, `rdata_o` is 0 and `block_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| view_i | input | 3 | View code of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| req_id_i | input | ID_W (3) | ID of the requester |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid while rd_i is high |
| block_o | output | 1 | Blocking take at zero: requester must stall |
| wake_o | output | 1 | One-cycle pulse releasing all waiters |
| waiters_o | output | N_REQ (8) | Bitmask of blocked requesters |

## Verification
On every cycle, the assertions check the following. A take lowers a nonzero count by exactly one. A give at the ceiling holds the count at 0xFFFF. A stall response only occurs at zero, returns zero and records a waiter. A give with waiters present produces a single-cycle wake and an empty mask. Raw-view writes leave the count alone. The tag word's empty and full flags track the count. Only the bench scenarios can show the rest: that the value returned is the pre-decrement one across a sequence, that give data and the choice of semaphore view make no difference, that all 65535 steps up to the ceiling are taken, that unused views and a simultaneous read and write behave as stated, and that reset clears the trap flag and the waiter mask.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;
  typedef enum logic [2:0] {
    VIEW_RAW  = 3'd0,
    VIEW_TAG  = 3'd1,
    VIEW_WAIT = 3'd2,
    VIEW_POLL = 3'd3
  } view_e;

  localparam int TAG_EMPTY_BIT = 0;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_TRAP_BIT  = 16;
endpackage

// File: rtl/sem_count.sv
module sem_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);
  assign full_o = (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
    else if (inc_i && !full_o)  cnt_q <= cnt_q + 1'b1;  // saturate at ceiling
  end
endmodule

// File: rtl/sem_waiters.sv
module sem_waiters #(
  parameter int N_REQ = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             block_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             release_i,
  output logic [N_REQ-1:0] waiters_o,
  output logic             wake_o
);
  logic [N_REQ-1:0] mask_q;
  logic             wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= release_i && (mask_q != '0);
      if (release_i)    mask_q <= '0;
      else if (block_i) mask_q[id_i] <= 1'b1;
    end
  end

  assign waiters_o = mask_q;
  assign wake_o    = wake_q;
endmodule

// File: rtl/sem_tag_word.sv
module sem_tag_word #(
  parameter int DATA_W = 32
) (
  input  logic              zero_i,
  input  logic              full_i,
  input  logic              trap_i,
  output logic [DATA_W-1:0] word_o
);
  import sem_cell_pkg::*;

  always_comb begin
    word_o                = '0;
    word_o[TAG_EMPTY_BIT] = zero_i;
    word_o[TAG_FULL_BIT]  = full_i;
    word_o[TAG_TRAP_BIT]  = trap_i;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_cell_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_REQ  = 8,
  parameter int DATA_W = 32,
  localparam int ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        view_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              block_o,
  output logic              wake_o,
  output logic [N_REQ-1:0]  waiters_o
);
  logic             is_sem, is_raw, is_tag, is_wait;
  logic             do_wr, take, give, tag_wr;
  logic [CNT_W-1:0] cnt_q;
  logic             zero, full;
  logic             trap_q;
  logic [DATA_W-1:0] tag_word;

  assign is_raw  = (view_i == VIEW_RAW);
  assign is_tag  = (view_i == VIEW_TAG);
  assign is_wait = (view_i == VIEW_WAIT);
  assign is_sem  = is_wait || (view_i == VIEW_POLL);

  // read wins when both strobes are high
  assign do_wr   = wr_i && !rd_i;
  assign take    = rd_i && is_sem;
  assign give    = do_wr && is_sem;
  assign tag_wr  = do_wr && is_tag;
  assign block_o = rd_i && is_wait && zero;

  sem_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (take),
    .inc_i  (give),
    .cnt_o  (cnt_q),
    .zero_o (zero),
    .full_o (full)
  );

  sem_waiters #(.N_REQ(N_REQ), .ID_W(ID_W)) u_waiters (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .block_i   (block_o),
    .id_i      (req_id_i),
    .release_i (give),
    .waiters_o (waiters_o),
    .wake_o    (wake_o)
  );

  sem_tag_word #(.DATA_W(DATA_W)) u_tag (
    .zero_i (zero),
    .full_i (full),
    .trap_i (trap_q),
    .word_o (tag_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trap_q <= 1'b0;
    else if (tag_wr) trap_q <= wdata_i[TAG_TRAP_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (is_raw || is_sem) rdata_o[CNT_W-1:0] = cnt_q;
      else if (is_tag)      rdata_o = tag_word;
    end
  end
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
  parameter int CNT_W  = 16,
  parameter int N_REQ  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        view_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              block_o,
  input logic              wake_o,
  input logic [N_REQ-1:0]  waiters_o,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sem_v;
  assign sem_v = (view_i == 3'd2) || (view_i == 3'd3);

  a_r2_dec_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sem_v && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r3_block_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> (cnt == '0 && rdata_o == '0));

  a_r3_waiter_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> (waiters_o != '0));

  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && sem_v && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  a_r5_wake_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && sem_v && waiters_o != '0) |=> (wake_o && waiters_o == '0));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  a_r7_raw_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && view_i == 3'd0) |=> $stable(cnt));

  a_r8_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && view_i == 3'd1) |-> (rdata_o[0] == (cnt == '0) && rdata_o[1] == (cnt == CNT_MAX)));
endmodule

bind sem_cell sem_cell_chk #(.CNT_W(CNT_W), .N_REQ(N_REQ), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .view_i    (view_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .rdata_o   (rdata_o),
  .block_o   (block_o),
  .wake_o    (wake_o),
  .waiters_o (waiters_o),
  .cnt       (cnt_q)
);

// File: tb/sem_cell_tb.sv
`timescale 1ns/1ps
module sem_cell_tb;
  localparam int N_REQ  = 8;
  localparam int DATA_W = 32;
  localparam int ID_W   = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        view = '0;
  logic              rd = 1'b0, wr = 1'b0;
  logic [ID_W-1:0]   rid = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              blk, wake;
  logic [N_REQ-1:0]  waiters;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sem_cell u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .view_i(view), .rd_i(rd), .wr_i(wr),
    .req_id_i(rid), .wdata_i(wdata), .rdata_o(rdata), .block_o(blk),
    .wake_o(wake), .waiters_o(waiters)
  );

  typedef struct packed {
    logic [2:0]  view;
    logic        rd;
    logic        wr;
    logic [2:0]  id;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        blk;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,     1'b0, 8'd3},  // R3 poll at zero
    '{3'd2, 1'b1, 1'b0, 3'd2, 32'h0,         32'h0,     1'b1, 8'd3},  // R3 block at zero
    '{3'd1, 1'b1, 1'b0, 3'd0, 32'h0,         32'h1,     1'b0, 8'd8},  // R8 empty flag
    '{3'd2, 1'b0, 1'b1, 3'd0, 32'hABCD,      32'h0,     1'b0, 8'd6},  // R6 give, data ignored -> 1
    '{3'd3, 1'b0, 1'b1, 3'd0, 32'h0,         32'h0,     1'b0, 8'd6},  // R6 polling give -> 2
    '{3'd0, 1'b1, 1'b0, 3'd0, 32'h0,         32'h2,     1'b0, 8'd7},  // R7 raw read
    '{3'd0, 1'b0, 1'b1, 3'd0, 32'h55,        32'h0,     1'b0, 8'd7},  // R7 raw write ignored
    '{3'd0, 1'b1, 1'b0, 3'd0, 32'h0,         32'h2,     1'b0, 8'd7},  // R7 unchanged
    '{3'd2, 1'b1, 1'b0, 3'd1, 32'h0,         32'h2,     1'b0, 8'd1},  // R1 pre value -> 1
    '{3'd3, 1'b1, 1'b0, 3'd0, 32'h0,         32'h1,     1'b0, 8'd2},  // R2 -> 0
    '{3'd3, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,     1'b0, 8'd2},  // R2 stops at 0
    '{3'd1, 1'b1, 1'b0, 3'd0, 32'h0,         32'h1,     1'b0, 8'd8},
    '{3'd1, 1'b0, 1'b1, 3'd0, 32'h0001_0003, 32'h0,     1'b0, 8'd8},  // R8 trap set
    '{3'd1, 1'b1, 1'b0, 3'd0, 32'h0,         32'h10001, 1'b0, 8'd8},
    '{3'd5, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,     1'b0, 8'd10}, // R10 unused view
    '{3'd6, 1'b0, 1'b1, 3'd0, 32'h0,         32'h0,     1'b0, 8'd10},
    '{3'd0, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,     1'b0, 8'd10},
    '{3'd2, 1'b0, 1'b1, 3'd0, 32'h0,         32'h0,     1'b0, 8'd4},  // R4 -> 1
    '{3'd3, 1'b1, 1'b1, 3'd0, 32'h0,         32'h1,     1'b0, 8'd11}, // R11 read only -> 0
    '{3'd0, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,     1'b0, 8'd11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // drive at negedge, sample combinational outputs before the edge
  task automatic acc(input logic [2:0] v, input logic r, input logic w, input logic [2:0] id,
                     input logic [31:0] d, output logic [31:0] q, output logic b);
    @(negedge clk);
    view = v; rd = r; wr = w; rid = id; wdata = d;
    #2;
    q = rdata; b = blk;
    @(posedge clk);
    #1;
    rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    logic        b;
    repeat (3) @(posedge clk);
    // R9 reset state
    check("R9 waiters", {24'h0, waiters}, 32'h0);
    check("R9 wake", {31'h0, wake}, 32'h0);
    #1 rst_ni = 1'b1;
    acc(3'd1, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R9 tag", q, 32'h1);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].view, VEC[i].rd, VEC[i].wr, VEC[i].id, VEC[i].wdata, q, b);
      check($sformatf("R%0d rdata vec%0d", VEC[i].req, i), q, VEC[i].exp);
      check($sformatf("R%0d block vec%0d", VEC[i].req, i), {31'h0, b}, {31'h0, VEC[i].blk});
    end

    // R12 idle outputs
    @(negedge clk);
    view = 3'd0; #2;
    check("R12 idle rdata", rdata, 32'h0);
    check("R12 idle block", {31'h0, blk}, 32'h0);

    // R3 and R5: two waiters, then a polling give
    acc(3'd2, 1'b1, 1'b0, 3'd1, 32'h0, q, b);
    acc(3'd2, 1'b1, 1'b0, 3'd5, 32'h0, q, b);
    @(negedge clk);
    check("R3 waiter mask", {24'h0, waiters}, 32'h22);
    acc(3'd3, 1'b0, 1'b1, 3'd0, 32'hFFFF_FFFF, q, b);
    @(negedge clk);
    check("R5 wake pulse", {31'h0, wake}, 32'h1);
    check("R5 mask cleared", {24'h0, waiters}, 32'h0);
    @(negedge clk);
    check("R5 wake one cycle", {31'h0, wake}, 32'h0);
    acc(3'd3, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R1 after wake", q, 32'h1);

    // R4 saturation
    for (int k = 0; k < 65535; k++) acc(3'd2, 1'b0, 1'b1, 3'd0, k, q, b);
    acc(3'd1, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R8 full flag", q, 32'h10002);
    acc(3'd3, 1'b0, 1'b1, 3'd0, 32'h0, q, b);
    acc(3'd0, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R4 saturated", q, 32'hFFFF);
    acc(3'd3, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R1 take at ceiling", q, 32'hFFFF);
    acc(3'd0, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R2 below ceiling", q, 32'hFFFE);
    acc(3'd1, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R8 no flags", q, 32'h10000);

    // R9 reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #3;
    check("R9 async waiters", {24'h0, waiters}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    acc(3'd0, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R9 count cleared", q, 32'h0);
    acc(3'd1, 1'b1, 1'b0, 3'd0, 32'h0, q, b);
    check("R9 trap cleared", q, 32'h1);

    finish_run();
  end
endmodule